// File: doc/BRIEF.md
# Serial Controller Status Flag Unit

This block builds the 32-bit read-only status word of a synchronous serial controller. The controller has a transmit holding register that feeds a transmit shift register, a receive holding register, and a current counter and a next counter for DMA transfers in each direction. The unit does no serial shifting itself, and it has no clocking, framing or DMA engine. It watches one-cycle event strobes from those parts, together with the live counter values, and keeps the flags that software polls.

Every flag is held in a flop with a synchronous, active-high reset. A strobe seen at a rising edge shows in the status word from that edge onward, so the word lags its cause by one cycle. The overrun, compare and sync flags are sticky and clear only when the status word is read. The two end-of-transfer flags re-arm on a write to either counter of their direction. A separate transmit-empty flag follows both the holding register and the shift register.

Top module: `ser_status_unit`

## Requirements
- R1: While reset is held, the status word is 32'h0000_0003: bits 0 and 1 are 1 and every other bit is 0.
- R2: Bit 0 (transmit ready) goes to 0 the cycle after a holding write. It returns to 1 the cycle after a holding-to-shift transfer that has no holding write in the same cycle. A write and a transfer in the same cycle leave the holding register full.
- R3: Bit 1 (transmit empty) is 1 only when the holding register is empty and the shift register is idle. A transfer makes the shift register busy. A shift-done strobe without a transfer in the same cycle makes it idle.
- R4: Bit 2 (transmit end) goes to 0 the cycle after a write to the transmit current counter or the transmit next counter. In any cycle with no such write and a transmit current count of 0, it becomes 1 and stays 1 until the next write.
- R5: Bit 3 shows, one cycle late, whether the transmit current count and the transmit next count are both 0.
- R6: Bit 4 (receive ready) goes to 1 the cycle after a receive load. It goes to 0 the cycle after a receive read that has no load in the same cycle.
- R7: Bit 5 (overrun) goes to 1 after a receive load that arrives while bit 4 is 1 and with no receive read in the same cycle. It stays 1 until a status read, which clears it.
- R8: If an overrun event and a status read fall in the same cycle, bit 5 is 1 afterwards.
- R9: Bit 6 (receive end) follows the rule of R4, using the receive current counter and the receive next-counter writes.
- R10: Bit 7 shows, one cycle late, whether the receive current count and the receive next count are both 0.
- R11: Bits 8 and 9 (compare 0 and 1) and bits 10 and 11 (transmit and receive sync) are set by their event strobes. Each is cleared by a status read, and a new event wins over a read in the same cycle.
- R12: Bits 16 and 17 show the transmit and receive enable inputs, one cycle late. Bits 12 to 15 and 18 to 31 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_wr | input | 1 | Transmit holding register written |
| hold_xfer | input | 1 | Holding data moved into the transmit shift register |
| shift_done | input | 1 | Transmit shift register finished sending |
| rx_load | input | 1 | Receive holding register loaded |
| rx_read | input | 1 | Receive holding register read |
| stat_rd | input | 1 | Status word read |
| tx_cur_wr | input | 1 | Transmit current counter written |
| tx_nxt_wr | input | 1 | Transmit next counter written |
| rx_cur_wr | input | 1 | Receive current counter written |
| rx_nxt_wr | input | 1 | Receive next counter written |
| tx_cur | input | CNT_W | Transmit current count |
| tx_nxt | input | CNT_W | Transmit next count |
| rx_cur | input | CNT_W | Receive current count |
| rx_nxt | input | CNT_W | Receive next count |
| cmp_hit | input | 2 | Compare events 0 and 1 |
| sync_hit | input | 2 | Sync events (0 transmit, 1 receive) |
| tx_en | input | 1 | Transmitter enabled |
| rx_en | input | 1 | Receiver enabled |
| status | output | 32 | Status word |

## Verification
The bench aims at the same-cycle collisions. It checks a holding write together with a transfer, a receive load together with a read, and an overrun event together with a status read. A design that got the priority wrong would show transmit ready or receive ready too early, or would lose an overrun. It also reloads the counters after they reach zero, so an end flag that failed to re-arm on a next-counter write, or that stayed 0 after the count had ended, disagrees with the model. A long seeded stretch of mixed strobes then compares every bit of the word, every cycle, against a model built from the requirements.

// File: rtl/ser_status_pkg.sv
`timescale 1ns/1ps
package ser_status_pkg;
  localparam int STAT_W     = 32;
  localparam int B_TX_RDY   = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_TX_END   = 2;
  localparam int B_TX_BUFE  = 3;
  localparam int B_RX_RDY   = 4;
  localparam int B_RX_OVR   = 5;
  localparam int B_RX_END   = 6;
  localparam int B_RX_BUFF  = 7;
  localparam int B_STICKY   = 8;   // compare 0, compare 1, tx sync, rx sync
  localparam int N_STICKY   = 4;
  localparam int B_TX_EN    = 16;
  localparam int B_RX_EN    = 17;
  localparam int N_DIR      = 2;   // 0 transmit, 1 receive
endpackage

// File: rtl/ser_tx_flags.sv
`timescale 1ns/1ps
module ser_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic hold_wr,
  input  logic hold_xfer,
  input  logic shift_done,
  output logic tx_ready,
  output logic tx_empty
);
  logic hold_full_q, shift_busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q  <= 1'b0;
      shift_busy_q <= 1'b0;
    end else begin
      // a fresh write outweighs the transfer of the older data
      if (hold_wr)        hold_full_q <= 1'b1;
      else if (hold_xfer) hold_full_q <= 1'b0;
      // a new transfer outweighs completion of the previous shift
      if (hold_xfer)       shift_busy_q <= 1'b1;
      else if (shift_done) shift_busy_q <= 1'b0;
    end
  end

  assign tx_ready = !hold_full_q;
  assign tx_empty = !hold_full_q && !shift_busy_q;

  // R2: a holding write always leaves the holding register occupied
  a_r2_write_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    hold_wr |=> !tx_ready);
  // R2: a transfer without a write empties the holding register
  a_r2_xfer_frees_hold: assert property (@(posedge clk) disable iff (rst)
    (hold_xfer && !hold_wr) |=> tx_ready);
  // R3: a transfer keeps the transmitter non-empty
  a_r3_xfer_not_empty: assert property (@(posedge clk) disable iff (rst)
    hold_xfer |=> !tx_empty);
  // R3: finishing the shift with nothing queued empties the transmitter
  a_r3_done_empties: assert property (@(posedge clk) disable iff (rst)
    (shift_done && !hold_xfer && !hold_wr && tx_ready) |=> tx_empty);
endmodule

// File: rtl/ser_rx_flags.sv
`timescale 1ns/1ps
module ser_rx_flags (
  input  logic clk,
  input  logic rst,
  input  logic rx_load,
  input  logic rx_read,
  input  logic stat_rd,
  output logic rx_ready,
  output logic rx_ovr
);
  logic full_q, ovr_q, ovr_evt;

  assign ovr_evt = rx_load && full_q && !rx_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rx_load)      full_q <= 1'b1;
      else if (rx_read) full_q <= 1'b0;
      // an event in the same cycle as a status read must survive
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
    end
  end

  assign rx_ready = full_q;
  assign rx_ovr   = ovr_q;

  // R6
  a_r6_load_sets_ready: assert property (@(posedge clk) disable iff (rst)
    rx_load |=> rx_ready);
  a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
    (rx_read && !rx_load) |=> !rx_ready);
  // R7 and R8: an unread load sets overrun even against a status read
  a_r8_overrun_kept: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rx_ready && !rx_read) |=> rx_ovr);
  // R7: a status read with no new overrun clears it
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(rx_load && rx_ready && !rx_read)) |=> !rx_ovr);
  // R7: overrun is sticky without a status read
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !stat_rd) |=> rx_ovr);
endmodule

// File: rtl/ser_dma_end.sv
`timescale 1ns/1ps
module ser_dma_end #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic             cur_wr,
  input  logic             nxt_wr,
  output logic             end_flag,
  output logic             bufe_flag
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic end_q, bufe_q, rearm;

  assign rearm = cur_wr || nxt_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q  <= 1'b0;
      bufe_q <= 1'b0;
    end else begin
      if (rearm)                end_q <= 1'b0;
      else if (cur_cnt == ZERO) end_q <= 1'b1;
      bufe_q <= (cur_cnt == ZERO) && (nxt_cnt == ZERO);
    end
  end

  assign end_flag  = end_q;
  assign bufe_flag = bufe_q;

  // R4 and R9: any counter write re-arms the end flag
  a_r4_rearm: assert property (@(posedge clk) disable iff (rst)
    rearm |=> !end_flag);
  // R4 and R9: an ended count raises the flag
  a_r9_reach_zero: assert property (@(posedge clk) disable iff (rst)
    (!rearm && cur_cnt == ZERO) |=> end_flag);
  // R4 and R9: the flag stays until a write
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (end_flag && !rearm) |=> end_flag);
  // R5 and R10: pending transfers mean the buffers are not empty
  a_r5_pending: assert property (@(posedge clk) disable iff (rst)
    (cur_cnt != ZERO || nxt_cnt != ZERO) |=> !bufe_flag);
  a_r10_drained: assert property (@(posedge clk) disable iff (rst)
    (cur_cnt == ZERO && nxt_cnt == ZERO) |=> bufe_flag);
endmodule

// File: rtl/ser_sticky_bank.sv
`timescale 1ns/1ps
module ser_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)         q <= 1'b0;
      else if (hit[i]) q <= 1'b1;
      else if (rd_clr) q <= 1'b0;
    end
    assign flags[i] = q;

    // R11
    a_r11_hit_sets: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> flags[i]);
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !hit[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/ser_status_unit.sv
`timescale 1ns/1ps
module ser_status_unit
  import ser_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_wr,
  input  logic             hold_xfer,
  input  logic             shift_done,
  input  logic             rx_load,
  input  logic             rx_read,
  input  logic             stat_rd,
  input  logic             tx_cur_wr,
  input  logic             tx_nxt_wr,
  input  logic             rx_cur_wr,
  input  logic             rx_nxt_wr,
  input  logic [CNT_W-1:0] tx_cur,
  input  logic [CNT_W-1:0] tx_nxt,
  input  logic [CNT_W-1:0] rx_cur,
  input  logic [CNT_W-1:0] rx_nxt,
  input  logic [1:0]       cmp_hit,
  input  logic [1:0]       sync_hit,
  input  logic             tx_en,
  input  logic             rx_en,
  output logic [31:0]      status
);
  logic tx_ready, tx_empty, rx_ready, rx_ovr;
  logic [N_DIR-1:0]             end_f, bufe_f, cur_w, nxt_w;
  logic [N_DIR-1:0][CNT_W-1:0]  cur_c, nxt_c;
  logic [N_STICKY-1:0]          sticky;
  logic                         tx_en_q, rx_en_q;

  ser_tx_flags u_tx (
    .clk(clk), .rst(rst), .hold_wr(hold_wr), .hold_xfer(hold_xfer),
    .shift_done(shift_done), .tx_ready(tx_ready), .tx_empty(tx_empty));

  ser_rx_flags u_rx (
    .clk(clk), .rst(rst), .rx_load(rx_load), .rx_read(rx_read),
    .stat_rd(stat_rd), .rx_ready(rx_ready), .rx_ovr(rx_ovr));

  assign cur_c = {rx_cur, tx_cur};
  assign nxt_c = {rx_nxt, tx_nxt};
  assign cur_w = {rx_cur_wr, tx_cur_wr};
  assign nxt_w = {rx_nxt_wr, tx_nxt_wr};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ser_dma_end #(.CNT_W(CNT_W)) u_end (
      .clk(clk), .rst(rst), .cur_cnt(cur_c[d]), .nxt_cnt(nxt_c[d]),
      .cur_wr(cur_w[d]), .nxt_wr(nxt_w[d]),
      .end_flag(end_f[d]), .bufe_flag(bufe_f[d]));
  end

  ser_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst(rst), .hit({sync_hit, cmp_hit}), .rd_clr(stat_rd),
    .flags(sticky));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      tx_en_q <= tx_en;
      rx_en_q <= rx_en;
    end
  end

  always_comb begin
    status = '0;
    status[B_TX_RDY]   = tx_ready;
    status[B_TX_EMPTY] = tx_empty;
    status[B_TX_END]   = end_f[0];
    status[B_TX_BUFE]  = bufe_f[0];
    status[B_RX_RDY]   = rx_ready;
    status[B_RX_OVR]   = rx_ovr;
    status[B_RX_END]   = end_f[1];
    status[B_RX_BUFF]  = bufe_f[1];
    status[B_STICKY +: N_STICKY] = sticky;
    status[B_TX_EN]    = tx_en_q;
    status[B_RX_EN]    = rx_en_q;
  end

  // R12: unused bits never rise
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (status[15:12] == 4'h0) && (status[31:18] == 14'h0));
  // R12: enables follow their inputs one cycle late
  a_r12_enable_follow: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> status[B_TX_EN]);
  // R1: reset state on the cycle after reset is sampled
  a_r1_reset_word: assert property (@(posedge clk)
    rst |=> (status == 32'h0000_0003));
endmodule

// File: tb/ser_status_unit_tb.sv
`timescale 1ns/1ps
module ser_status_unit_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_wr, hold_xfer, shift_done, rx_load, rx_read, stat_rd;
  logic tx_cur_wr, tx_nxt_wr, rx_cur_wr, rx_nxt_wr;
  logic [CNT_W-1:0] tx_cur, tx_nxt, rx_cur, rx_nxt;
  logic [1:0] cmp_hit, sync_hit;
  logic tx_en, rx_en;
  logic [31:0] status;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ser_status_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .hold_wr(hold_wr), .hold_xfer(hold_xfer),
    .shift_done(shift_done), .rx_load(rx_load), .rx_read(rx_read),
    .stat_rd(stat_rd), .tx_cur_wr(tx_cur_wr), .tx_nxt_wr(tx_nxt_wr),
    .rx_cur_wr(rx_cur_wr), .rx_nxt_wr(rx_nxt_wr), .tx_cur(tx_cur),
    .tx_nxt(tx_nxt), .rx_cur(rx_cur), .rx_nxt(rx_nxt), .cmp_hit(cmp_hit),
    .sync_hit(sync_hit), .tx_en(tx_en), .rx_en(rx_en), .status(status));

  // reference model state
  logic m_hold, m_busy, m_tend, m_tbufe, m_rfull, m_ovr, m_rend, m_rbuff;
  logic [3:0] m_stk;
  logic m_txen, m_rxen;
  logic [31:0] exp_q[$];

  function automatic string req_of(int b);
    case (b)
      0: return "R2 tx ready";
      1: return "R3 tx empty";
      2: return "R4 tx end";
      3: return "R5 tx bufe";
      4: return "R6 rx ready";
      5: return "R7 overrun";
      6: return "R9 rx end";
      7: return "R10 rx buff";
      8, 9, 10, 11: return "R11 sticky";
      default: return "R12 enable/unused";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    {hold_wr, hold_xfer, shift_done, rx_load, rx_read, stat_rd} = '0;
    {tx_cur_wr, tx_nxt_wr, rx_cur_wr, rx_nxt_wr} = '0;
    cmp_hit = '0; sync_hit = '0;
  endtask

  task automatic model_reset();
    m_hold = 0; m_busy = 0; m_tend = 0; m_tbufe = 0;
    m_rfull = 0; m_ovr = 0; m_rend = 0; m_rbuff = 0;
    m_stk = '0; m_txen = 0; m_rxen = 0;
  endtask

  // driver: applies current inputs for one edge, pushes the expected word
  task automatic tick();
    logic ovr_evt;
    logic [3:0] hits;
    logic [31:0] w;
    ovr_evt = rx_load && m_rfull && !rx_read;
    if (hold_wr) m_hold = 1; else if (hold_xfer) m_hold = 0;
    if (hold_xfer) m_busy = 1; else if (shift_done) m_busy = 0;
    if (tx_cur_wr || tx_nxt_wr) m_tend = 0; else if (tx_cur == 0) m_tend = 1;
    m_tbufe = (tx_cur == 0) && (tx_nxt == 0);
    if (rx_cur_wr || rx_nxt_wr) m_rend = 0; else if (rx_cur == 0) m_rend = 1;
    m_rbuff = (rx_cur == 0) && (rx_nxt == 0);
    if (ovr_evt) m_ovr = 1; else if (stat_rd) m_ovr = 0;
    if (rx_load) m_rfull = 1; else if (rx_read) m_rfull = 0;
    hits = {sync_hit, cmp_hit};
    for (int i = 0; i < 4; i++)
      if (hits[i]) m_stk[i] = 1; else if (stat_rd) m_stk[i] = 0;
    m_txen = tx_en; m_rxen = rx_en;
    w = '0;
    w[0] = !m_hold; w[1] = !m_hold && !m_busy; w[2] = m_tend; w[3] = m_tbufe;
    w[4] = m_rfull; w[5] = m_ovr; w[6] = m_rend; w[7] = m_rbuff;
    w[11:8] = m_stk; w[16] = m_txen; w[17] = m_rxen;
    exp_q.push_back(w);
    @(negedge clk);
    idle();
  endtask

  // monitor: compares each result shortly after the edge that produced it
  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [31:0] e;
      #2;
      e = exp_q.pop_front();
      for (int b = 0; b < 32; b++)
        check(status[b] == e[b], req_of(b), status, e);
    end
  end

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    idle();
    tx_cur = '0; tx_nxt = '0; rx_cur = '0; rx_nxt = '0; tx_en = 0; rx_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(status == 32'h0000_0003, "R1 reset word", status, 32'h3);
    rst = 0;

    // R2, R3: write, transfer, shift done
    tick(); tick();
    hold_wr = 1; tick();
    tick();
    hold_xfer = 1; tick();
    hold_wr = 1; tick();                 // R2: second write while shifting
    hold_wr = 1; hold_xfer = 1; tick();  // R2: write and transfer together
    hold_xfer = 1; tick();
    shift_done = 1; tick();
    shift_done = 1; tick();              // R3: shift finished, nothing queued
    tick();

    // R6, R7, R8: loads without reads, status-read collision
    rx_load = 1; tick();
    rx_load = 1; tick();                 // R7: overrun
    tick();
    stat_rd = 1; tick();                 // R7: read clears
    rx_load = 1; stat_rd = 1; tick();    // R8: event beats read
    tick();
    rx_load = 1; rx_read = 1; tick();    // R7: read in same cycle, no overrun
    stat_rd = 1; tick();
    rx_read = 1; tick();                 // R6: empty again
    tick();

    // R4, R5, R9, R10: counter reloads
    tx_cur = 5; tx_cur_wr = 1; tick();
    for (int k = 4; k >= 0; k--) begin tx_cur = k[CNT_W-1:0]; tick(); end
    tick();
    tx_nxt = 3; tx_nxt_wr = 1; tick();   // R4: next-counter write re-arms
    tx_cur = 3; tx_nxt = 0; tick();
    tx_cur = 0; tick(); tick();
    rx_cur = 2; rx_nxt = 1; rx_cur_wr = 1; tick();
    rx_cur = 1; tick();
    rx_cur = 0; tick();                  // R9
    rx_nxt_wr = 1; tick();               // R9: re-arm with count still 0
    rx_nxt = 0; tick(); tick();          // R10

    // R11, R12
    cmp_hit = 2'b01; sync_hit = 2'b10; tick();
    stat_rd = 1; cmp_hit = 2'b10; tick();
    stat_rd = 1; tick();
    tx_en = 1; tick();
    rx_en = 1; tx_en = 0; tick();
    tick();

    // mixed seeded traffic
    for (int n = 0; n < 400; n++) begin
      logic [19:0] r;
      r = 20'($urandom);
      hold_wr = r[0] & r[1]; hold_xfer = r[2]; shift_done = r[3];
      rx_load = r[4]; rx_read = r[5] & r[6]; stat_rd = r[7] & r[8];
      tx_cur_wr = r[9] & r[10] & r[11]; tx_nxt_wr = r[12] & r[13] & r[11];
      rx_cur_wr = r[9] & r[14] & r[15]; rx_nxt_wr = r[16] & r[13] & r[15];
      cmp_hit = {r[17] & r[18], r[18] & r[19]};
      sync_hit = {r[19] & r[1], r[17] & r[3]};
      tx_en = r[6]; rx_en = r[10];
      if (r[14]) tx_cur = (tx_cur == 0) ? CNT_W'(r[2:1]) : tx_cur - 1;
      if (r[16]) rx_cur = (rx_cur == 0) ? CNT_W'(r[4:3]) : rx_cur - 1;
      if (r[12] & r[8]) tx_nxt = CNT_W'(r[0]);
      if (r[13] & r[7]) rx_nxt = CNT_W'(r[5]);
      tick();
    end
    tick();
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule